// File: doc/BRIEF.md
# Narrow-to-32-bit register access converter

This block connects a narrow host access stream, fixed at 8 or 16 bits by a parameter, to a bank of 32-bit internal registers. Every 32-bit register spans four consecutive byte addresses. It is reached through two 16-bit accesses or four 8-bit accesses. The front end that decodes the host pins gives the block one request per access: a valid strobe, the direction, the byte address, the write data, the per-lane byte enables and an endianness bit. On the register side the block drives a 32-bit read port and a 32-bit write port with a 4-bit byte mask.

Writes are collected in a gather buffer. The block commits one masked 32-bit register write only when the last part of the dword arrives. Reads fetch the full 32-bit value when the first part is read and keep it in a holding register. The later parts come from that copy, so the host sees one consistent value even if the register changes between its accesses. Each access carries its own endianness bit, so the byte order can change from one access to the next.

Top module: `narrow_dword_bridge`

## Requirements
- R1: A write to the last part of a dword (part index 1 on a 16-bit bus, 3 on an 8-bit bus) produces exactly one register write. That write is on `reg_wr_en` one cycle after the access, with `reg_waddr` equal to the byte address shifted right by two. A write to any other part produces no register write.
- R2: The part index is the two low address bits divided by the number of lanes; a 16-bit bus ignores address bit 0. Host byte a = part*lanes + lane maps to dword byte a when the endianness input is 0 (little) and to byte 3-a when it is 1 (big). Dword byte i sits in bits [8i+7:8i].
- R3: The endianness bit is applied per access. Parts of one dword may use different settings. When two lanes land on the same dword byte, the later access wins.
- R4: Byte-enable bit j, active high, lets lane j take effect on a write. A disabled lane leaves its dword byte clear in `reg_wmask`, and its byte of `reg_wdata` reads zero.
- R5: A read of part 0 raises `reg_rd_en` in the same cycle, with `reg_raddr` set to the dword address, and samples `reg_rdata`. Every read returns `rd_valid` high and the lane data on `rd_data` one cycle after the access. Byte enables do not affect reads.
- R6: A read of a later part of the dword last fetched is served from the holding register without raising `reg_rd_en`. It returns the value captured at the fetch, even if the register has changed since.
- R7: A read of a later part raises a fresh fetch and restarts the hold in two cases: when no valid hold exists, and when the hold belongs to another dword.
- R8: Any access, read or write, to a dword other than the one being gathered discards the buffered write parts.
- R9: Any write access invalidates the read holding register.
- R10: A last-part write that leaves the gathered byte mask empty produces no register write.
- R11: During and after reset with no access, `rd_valid`, `reg_wr_en` and `reg_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One host access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | HOST_W | Write data, lane j in bits [8j+7:8j] |
| acc_be | input | HOST_W/8 | Per-lane write enables, active high |
| acc_big | input | 1 | 1 = big-endian lane mapping for this access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | HOST_W | Read data for the part |
| reg_rd_en | output | 1 | Register fetch strobe |
| reg_raddr | output | ADDR_W-2 | Dword address of the fetch |
| reg_rdata | input | 32 | Register value, valid in the fetch cycle |
| reg_wr_en | output | 1 | Register write strobe |
| reg_waddr | output | ADDR_W-2 | Dword address of the write |
| reg_wdata | output | 32 | Assembled write data |
| reg_wmask | output | 4 | Byte mask of the write |

## Verification
The fetch strobe and fetch address are combinational from the access. The bench reads them 1 ns after driving a request. The read lanes and a committed register write both come out of one register stage, so they are due at the edge after the access. The bench reads them at the following falling edge, then drops the request. An idle cycle separates accesses, so that a commit has reached the bench register model before the next fetch reads it.

// File: rtl/nb_pkg.sv
package nb_pkg;
   localparam int DWORD_BYTES = 4;

   typedef logic [1:0] bsel_t;

   // Host byte position inside a dword -> dword byte index.
   function automatic bsel_t host_to_dword_byte(input int unsigned host_byte, input logic big);
      bsel_t pos;
      pos = bsel_t'(host_byte);
      return big ? bsel_t'(2'd3 - pos) : pos;
   endfunction
endpackage

// File: rtl/nb_lane_map.sv
module nb_lane_map #(
   parameter int LANES  = 2,
   parameter int PART_W = 1
) (
   input  logic [PART_W-1:0]       part,
   input  logic                    big,
   output logic [LANES-1:0][1:0]   sel
);
   import nb_pkg::*;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign sel[j] = host_to_dword_byte(int'(part) * LANES + j, big);
   end
endmodule

// File: rtl/nb_wr_gather.sv
module nb_wr_gather #(
   parameter int LANES = 2,
   parameter int TAG_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit,
   input  logic                  is_wr,
   input  logic                  is_last,
   input  logic [TAG_W-1:0]      tag,
   input  logic [LANES-1:0][1:0] sel,
   input  logic [LANES*8-1:0]    wdata,
   input  logic [LANES-1:0]      be,
   output logic                  reg_wr_en,
   output logic [TAG_W-1:0]      reg_waddr,
   output logic [31:0]           reg_wdata,
   output logic [3:0]            reg_wmask
);
   logic [31:0]      buf_data;
   logic [3:0]       buf_mask;
   logic [TAG_W-1:0] buf_tag;
   logic             same_dw;
   logic [31:0]      mrg_data;
   logic [3:0]       mrg_mask;

   assign same_dw = (buf_tag == tag);

   always_comb begin
      mrg_data = same_dw ? buf_data : '0;
      mrg_mask = same_dw ? buf_mask : '0;
      for (int j = 0; j < LANES; j++) begin
         if (be[j]) begin
            mrg_data[{sel[j], 3'b000} +: 8] = wdata[j*8 +: 8];
            mrg_mask[sel[j]] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_data  <= '0;
         buf_mask  <= '0;
         buf_tag   <= '0;
         reg_wr_en <= 1'b0;
         reg_waddr <= '0;
         reg_wdata <= '0;
         reg_wmask <= '0;
      end else begin
         reg_wr_en <= 1'b0;
         if (hit && is_wr) begin
            buf_tag <= tag;
            if (is_last) begin
               if (mrg_mask != '0) begin
                  reg_wr_en <= 1'b1;
                  reg_waddr <= tag;
                  reg_wdata <= mrg_data;
                  reg_wmask <= mrg_mask;
               end
               buf_data <= '0;
               buf_mask <= '0;
            end else begin
               buf_data <= mrg_data;
               buf_mask <= mrg_mask;
            end
         end else if (hit && !same_dw) begin
            buf_data <= '0;
            buf_mask <= '0;
         end
      end
   end
endmodule

// File: rtl/nb_rd_hold.sv
module nb_rd_hold #(
   parameter int LANES = 2,
   parameter int TAG_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit,
   input  logic                  is_wr,
   input  logic                  is_first,
   input  logic [TAG_W-1:0]      tag,
   input  logic [LANES-1:0][1:0] sel,
   input  logic [31:0]           reg_rdata,
   output logic                  reg_rd_en,
   output logic                  rd_valid,
   output logic [LANES*8-1:0]    rd_data
);
   logic [31:0]        hold_data;
   logic [TAG_W-1:0]   hold_tag;
   logic               hold_ok;
   logic               is_rd;
   logic               fetch;
   logic [31:0]        src;
   logic [LANES*8-1:0] lane_d;

   assign is_rd = hit && !is_wr;
   assign fetch = is_rd && (is_first || !hold_ok || (hold_tag != tag));
   assign src   = fetch ? reg_rdata : hold_data;
   assign reg_rd_en = fetch;

   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         lane_d[j*8 +: 8] = src[{sel[j], 3'b000} +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_tag  <= '0;
         hold_ok   <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         rd_valid <= is_rd;
         if (is_rd) rd_data <= lane_d;
         if (fetch) begin
            hold_data <= reg_rdata;
            hold_tag  <= tag;
            hold_ok   <= 1'b1;
         end else if (hit && is_wr) begin
            hold_ok <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/narrow_dword_bridge.sv
module narrow_dword_bridge #(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [HOST_W-1:0]   acc_wdata,
   input  logic [HOST_W/8-1:0] acc_be,
   input  logic                acc_big,
   output logic                rd_valid,
   output logic [HOST_W-1:0]   rd_data,
   output logic                reg_rd_en,
   output logic [ADDR_W-3:0]   reg_raddr,
   input  logic [31:0]         reg_rdata,
   output logic                reg_wr_en,
   output logic [ADDR_W-3:0]   reg_waddr,
   output logic [31:0]         reg_wdata,
   output logic [3:0]          reg_wmask
);
   localparam int LANES    = HOST_W / 8;
   localparam int PARTS    = nb_pkg::DWORD_BYTES / LANES;
   localparam int PART_W   = (PARTS > 1) ? $clog2(PARTS) : 1;
   localparam int TAG_W    = ADDR_W - 2;

   if (HOST_W != 8 && HOST_W != 16) begin : g_bad_host_w
      $error("narrow_dword_bridge: HOST_W must be 8 or 16");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("narrow_dword_bridge: ADDR_W must be at least 3");
   end

   logic [PART_W-1:0]      part;
   logic [TAG_W-1:0]       tag;
   logic                   is_first;
   logic                   is_last;
   logic [LANES-1:0][1:0]  sel;

   if (LANES == 1) begin : g_byte_bus
      assign part = acc_addr[1:0];
   end else begin : g_half_bus
      logic unused_addr_lsb;
      assign part = acc_addr[1];
      assign unused_addr_lsb = acc_addr[0];
   end

   assign tag       = acc_addr[ADDR_W-1:2];
   assign is_first  = (part == '0);
   assign is_last   = (part == PART_W'(PARTS - 1));
   assign reg_raddr = tag;

   nb_lane_map #(.LANES(LANES), .PART_W(PART_W)) u_map (
      .part (part),
      .big  (acc_big),
      .sel  (sel)
   );

   nb_wr_gather #(.LANES(LANES), .TAG_W(TAG_W)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (acc_valid),
      .is_wr     (acc_write),
      .is_last   (is_last),
      .tag       (tag),
      .sel       (sel),
      .wdata     (acc_wdata),
      .be        (acc_be),
      .reg_wr_en (reg_wr_en),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .reg_wmask (reg_wmask)
   );

   nb_rd_hold #(.LANES(LANES), .TAG_W(TAG_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (acc_valid),
      .is_wr     (acc_write),
      .is_first  (is_first),
      .tag       (tag),
      .sel       (sel),
      .reg_rdata (reg_rdata),
      .reg_rd_en (reg_rd_en),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/nb_chk.sv
module nb_chk #(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              rd_valid,
   input logic              reg_rd_en,
   input logic [ADDR_W-3:0] reg_raddr,
   input logic              reg_wr_en,
   input logic [ADDR_W-3:0] reg_waddr,
   input logic [31:0]       reg_wdata,
   input logic [3:0]        reg_wmask
);
   localparam int LANES    = HOST_W / 8;
   localparam int LANE_LSB = (LANES > 1) ? 1 : 0;
   localparam int PARTS    = 4 / LANES;

   logic [1:0]  pidx;
   logic        first_p;
   logic        last_p;
   logic [31:0] bytes_on;

   assign pidx    = acc_addr[1:0] >> LANE_LSB;
   assign first_p = (pidx == 2'd0);
   assign last_p  = (pidx == 2'(PARTS - 1));

   always_comb begin
      for (int i = 0; i < 4; i++) bytes_on[i*8 +: 8] = {8{reg_wmask[i]}};
   end

   // R1
   commit_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $past(acc_valid && acc_write && last_p));
   // R1
   commit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> reg_waddr == $past(acc_addr[ADDR_W-1:2]));
   // R4
   masked_bytes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (reg_wdata & ~bytes_on) == 32'h0);
   // R10
   no_empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> reg_wmask != 4'h0);
   // R5
   first_read_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && first_p) |-> (reg_rd_en && reg_raddr == acc_addr[ADDR_W-1:2]));
   // R5
   read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> rd_valid);
   // R5
   no_stray_rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_valid && !acc_write));
   // R11
   fetch_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> (acc_valid && !acc_write));
   // R9
   write_drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_valid && acc_write) && acc_valid && !acc_write) |-> reg_rd_en);
endmodule

bind narrow_dword_bridge nb_chk #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_nb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .rd_valid  (rd_valid),
   .reg_rd_en (reg_rd_en),
   .reg_raddr (reg_raddr),
   .reg_wr_en (reg_wr_en),
   .reg_waddr (reg_waddr),
   .reg_wdata (reg_wdata),
   .reg_wmask (reg_wmask)
);

// File: tb/tb_narrow_dword_bridge.sv
`timescale 1ns/1ps
module tb_narrow_dword_bridge;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   // 16-bit instance
   logic a_valid = 0, a_wr = 0, a_big = 0;
   logic [AW-1:0] a_addr = '0;
   logic [15:0] a_wdata = '0;
   logic [1:0] a_be = '0;
   logic a_rdv, a_rden, a_we;
   logic [15:0] a_rd;
   logic [AW-3:0] a_raddr, a_waddr;
   logic [31:0] a_rdata, a_wd;
   logic [3:0] a_wm;
   // 8-bit instance
   logic b_valid = 0, b_wr = 0, b_big = 0;
   logic [AW-1:0] b_addr = '0;
   logic [7:0] b_wdata = '0;
   logic [0:0] b_be = '0;
   logic b_rdv, b_rden, b_we;
   logic [7:0] b_rd;
   logic [AW-3:0] b_raddr, b_waddr;
   logic [31:0] b_rdata, b_wd;
   logic [3:0] b_wm;

   narrow_dword_bridge #(.HOST_W(16), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(a_valid), .acc_write(a_wr), .acc_addr(a_addr),
      .acc_wdata(a_wdata), .acc_be(a_be), .acc_big(a_big), .rd_valid(a_rdv), .rd_data(a_rd),
      .reg_rd_en(a_rden), .reg_raddr(a_raddr), .reg_rdata(a_rdata), .reg_wr_en(a_we),
      .reg_waddr(a_waddr), .reg_wdata(a_wd), .reg_wmask(a_wm));

   narrow_dword_bridge #(.HOST_W(8), .ADDR_W(AW)) dut_b (
      .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_wr), .acc_addr(b_addr),
      .acc_wdata(b_wdata), .acc_be(b_be), .acc_big(b_big), .rd_valid(b_rdv), .rd_data(b_rd),
      .reg_rd_en(b_rden), .reg_raddr(b_raddr), .reg_rdata(b_rdata), .reg_wr_en(b_we),
      .reg_waddr(b_waddr), .reg_wdata(b_wd), .reg_wmask(b_wm));

   // bench register files
   logic [31:0] rfa [16];
   logic [31:0] rfb [16];
   logic [31:0] ema [16];
   logic [31:0] emb [16];
   logic        poke_en = 0;
   logic [3:0]  poke_idx = '0;
   logic [31:0] poke_val = '0;

   assign a_rdata = rfa[a_raddr];
   assign b_rdata = rfb[b_raddr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            rfa[i] <= 32'h01010101 * i;
            rfb[i] <= 32'h01010101 * i;
         end
      end else begin
         if (a_we) for (int i = 0; i < 4; i++) if (a_wm[i]) rfa[a_waddr][i*8 +: 8] <= a_wd[i*8 +: 8];
         if (b_we) for (int i = 0; i < 4; i++) if (b_wm[i]) rfb[b_waddr][i*8 +: 8] <= b_wd[i*8 +: 8];
         if (poke_en) rfa[poke_idx] <= poke_val;
      end
   end

   int n_cmp = 0;
   int n_bad = 0;
   logic        o_fetch, o_rdv, o_we;
   logic [15:0] o_rd;
   logic [3:0]  o_wa, o_wm;
   logic [31:0] o_wd;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int bidx(int part, int lanes, int lane, bit big);
      int a;
      a = part * lanes + lane;
      return big ? 3 - a : a;
   endfunction

   function automatic logic [15:0] host_of(logic [31:0] w, int part, int lanes, bit big);
      logic [15:0] h;
      h = '0;
      for (int lane = 0; lane < lanes; lane++) h[lane*8 +: 8] = w[bidx(part, lanes, lane, big)*8 +: 8];
      return h;
   endfunction

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] m);
      logic [31:0] r;
      r = old;
      for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = d[i*8 +: 8];
      return r;
   endfunction

   task automatic acc(input bit wide, input bit wr, input logic [AW-1:0] addr,
                      input logic [15:0] d, input logic [1:0] be, input bit big);
      @(negedge clk);
      if (wide) begin
         a_valid = 1; a_wr = wr; a_addr = addr; a_wdata = d; a_be = be; a_big = big;
      end else begin
         b_valid = 1; b_wr = wr; b_addr = addr; b_wdata = d[7:0]; b_be = be[0]; b_big = big;
      end
      #1;
      o_fetch = wide ? a_rden : b_rden;
      @(negedge clk);
      a_valid = 0;
      b_valid = 0;
      o_rdv = wide ? a_rdv : b_rdv;
      o_rd  = wide ? a_rd : {8'h00, b_rd};
      o_we  = wide ? a_we : b_we;
      o_wa  = wide ? a_waddr : b_waddr;
      o_wd  = wide ? a_wd : b_wd;
      o_wm  = wide ? a_wm : b_wm;
   endtask

   task automatic poke(input logic [3:0] idx, input logic [31:0] v);
      @(negedge clk);
      poke_en = 1; poke_idx = idx; poke_val = v;
      @(negedge clk);
      poke_en = 0;
   endtask

   task automatic sweep(input bit wide);
      int lanes, parts;
      lanes = wide ? 2 : 1;
      parts = 4 / lanes;
      for (int d = 0; d < 16; d++) begin
         for (int wb = 0; wb < 2; wb++) begin
            logic [31:0] w;
            w = 32'h9E3779B1 * (d * 2 + wb + 1);
            for (int k = 0; k < parts; k++) begin
               acc(wide, 1, AW'(d * 4 + k * lanes), host_of(w, k, lanes, wb[0]), 2'b11, wb[0]);
               if (k < parts - 1) begin
                  check("R1 no write before last part", {31'd0, o_we}, 32'd0);
               end else begin
                  check("R1 commit strobe", {31'd0, o_we}, 32'd1);
                  check("R1 commit address", {28'd0, o_wa}, 32'(d));
                  check("R2 assembled word", o_wd, w);
                  check("R4 full mask", {28'd0, o_wm}, 32'hF);
               end
            end
            if (wide) ema[d] = w; else emb[d] = w;
            for (int rb = 0; rb < 2; rb++) begin
               for (int k = 0; k < parts; k++) begin
                  acc(wide, 0, AW'(d * 4 + k * lanes), 16'h0, 2'b00, rb[0]);
                  check("R5 rd_valid", {31'd0, o_rdv}, 32'd1);
                  check(k == 0 ? "R5 fetch on first part" : "R6 no fetch on later part",
                        {31'd0, o_fetch}, (k == 0) ? 32'd1 : 32'd0);
                  check("R3 read lanes per endianness", {16'd0, o_rd},
                        {16'd0, host_of(wide ? ema[d] : emb[d], k, lanes, rb[0])});
               end
            end
         end
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         ema[i] = 32'h01010101 * i;
         emb[i] = 32'h01010101 * i;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 rd_valid in reset", {31'd0, a_rdv}, 32'd0);
      check("R11 write strobe in reset", {30'd0, a_we, b_we}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      @(negedge clk);
      check("R11 idle after reset", {28'd0, a_rdv, b_rdv, a_rden, b_rden}, 32'd0);
      check("R11 no write after reset", {30'd0, a_we, b_we}, 32'd0);

      sweep(1'b1);
      sweep(1'b0);

      // R3: mixed endianness within one dword, later lane wins on overlap
      acc(1, 1, AW'(9*4 + 0), 16'h5566, 2'b11, 0);
      acc(1, 1, AW'(9*4 + 2), 16'h7788, 2'b11, 1);
      check("R3 mixed-endian mask", {28'd0, o_wm}, 32'h3);
      check("R3 mixed-endian data", o_wd, 32'h00008877);

      // R4: byte enables pick lanes
      acc(1, 1, AW'(2*4 + 0), 16'h1122, 2'b01, 0);
      acc(1, 1, AW'(2*4 + 2), 16'h3344, 2'b10, 0);
      check("R4 partial mask", {28'd0, o_wm}, 32'h9);
      check("R4 partial data", o_wd, 32'h33000022);

      // R8: write to another dword discards gathered part
      acc(1, 1, AW'(3*4 + 0), 16'hAAAA, 2'b11, 0);
      acc(1, 1, AW'(4*4 + 2), 16'hBBCC, 2'b11, 0);
      check("R8 restart address", {28'd0, o_wa}, 32'd4);
      check("R8 restart mask", {28'd0, o_wm}, 32'hC);
      check("R8 restart data", o_wd, 32'hBBCC0000);
      ema[4] = merge(ema[4], 32'hBBCC0000, 4'hC);

      // R8: read of another dword also discards
      acc(1, 1, AW'(5*4 + 0), 16'h1111, 2'b11, 0);
      acc(1, 0, AW'(6*4 + 0), 16'h0, 2'b00, 0);
      acc(1, 1, AW'(5*4 + 2), 16'h2222, 2'b11, 0);
      check("R8 read restart mask", {28'd0, o_wm}, 32'hC);
      check("R8 read restart data", o_wd, 32'h22220000);
      ema[5] = merge(ema[5], 32'h22220000, 4'hC);

      // R10: empty mask never commits
      acc(1, 1, AW'(7*4 + 0), 16'hFFFF, 2'b00, 0);
      acc(1, 1, AW'(7*4 + 2), 16'hFFFF, 2'b00, 0);
      check("R10 no write on empty mask", {31'd0, o_we}, 32'd0);

      // R6: holding register keeps the captured value
      acc(1, 0, AW'(8*4 + 0), 16'h0, 2'b00, 0);
      check("R5 fetch part 0", {31'd0, o_fetch}, 32'd1);
      check("R5 part 0 data", {16'd0, o_rd}, {16'd0, ema[8][15:0]});
      poke(4'd8, 32'hC0FFEE11);
      acc(1, 0, AW'(8*4 + 2), 16'h0, 2'b00, 0);
      check("R6 held part, no fetch", {31'd0, o_fetch}, 32'd0);
      check("R6 held value", {16'd0, o_rd}, {16'd0, ema[8][31:16]});
      ema[8] = 32'hC0FFEE11;

      // R7: later part of another dword fetches
      acc(1, 0, AW'(10*4 + 2), 16'h0, 2'b00, 0);
      check("R7 fetch on other dword", {31'd0, o_fetch}, 32'd1);
      check("R7 fresh data", {16'd0, o_rd}, {16'd0, ema[10][31:16]});
      acc(1, 0, AW'(8*4 + 2), 16'h0, 2'b00, 0);
      check("R7 refetch after switch", {31'd0, o_fetch}, 32'd1);
      check("R7 new register value", {16'd0, o_rd}, 16'hC0FF);

      // R9: write access drops the hold
      acc(1, 0, AW'(8*4 + 0), 16'h0, 2'b00, 0);
      acc(1, 1, AW'(8*4 + 0), 16'h0, 2'b00, 0);
      acc(1, 0, AW'(8*4 + 2), 16'h0, 2'b00, 1);
      check("R9 fetch after write", {31'd0, o_fetch}, 32'd1);
      check("R9 big-endian part 1", {16'd0, o_rd}, {16'd0, host_of(ema[8], 1, 2, 1'b1)});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule